// File: doc/BRIEF.md
# Dot-Matrix Display Intensity and Flash Timing Generator

This block derives every timing signal a multiplexed eight-character 5x7 dot-matrix display needs from one oscillator clock. It walks through the seven dot rows, marking the start of each row slot with a one-cycle strobe. Inside each slot it gates the row drivers with a duty pattern chosen by a 3-bit brightness code. It also keeps a slow on/off phase that hides flashing characters, or the whole display while blinking, for half of each phase period.

A row slot lasts 32 clocks, so one full refresh frame lasts 7 x 32 = 224 clocks. The first 30 clocks of a slot form 15 sub-slots of 2 clocks each. The brightness code chooses how many leading sub-slots drive the dots, and the last 2 clocks of every slot are always dark. The phase bit flips every 128 frames, which is 28,672 clocks. Characters that follow the phase are visible while it is 0 and hidden while it is 1. All counters start from zero at reset, so several displays reset together on one clock stay in step.

All outputs are registered. Let t be the number of clock edges with reset low since reset was last sampled high. The outputs then show the state for count t, computed from the control inputs sampled at edge t.

Top module: `dot_matrix_timing`

## Requirements
- R1: `row_strobe` is 1 exactly when t is a nonzero multiple of 32 (slot position t mod 32 equals 0), and 0 otherwise.
- R2: `row_idx` equals (t / 32) mod 7 (integer division), so the rows run 0 to 6 and a refresh frame lasts 224 clocks.
- R3: With s = t mod 32 and N the sub-slot count of the brightness code, `dot_en` is 1 exactly when s < 2*N. Positions 30 and 31 of each slot are therefore always dark.
- R4: Brightness codes 0,1,2,3,4,5,6,7 (binary 000 to 111) give N = 15,12,8,6,4,3,2,0. Code 0 is the brightest, and code 7 holds `dot_en` at 0.
- R5: While `flash_en` and `blink_en` are both 0, every bit of `char_vis` is 1, whatever value `flash_attr` holds.
- R6: While `blink_en` is 0 and `flash_en` is 1, `char_vis[i]` equals NOT phase when `flash_attr[i]` is 1, and equals 1 when `flash_attr[i]` is 0.
- R7: While `blink_en` is 1, every bit of `char_vis` equals NOT phase, whatever `flash_en` and `flash_attr` hold. Blinking takes priority over flashing.
- R8: The phase equals (t / 28672) mod 2. It is 0 after reset and flips every 128 refresh frames.
- R9: A clock edge with `rst` high sets all outputs to 0 and clears every counter. The first edge after `rst` goes low gives the state for t = 1.
- R10: A control input sampled at a clock edge takes effect in the outputs registered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bright_code | input | 3 | Brightness code (0 brightest, 7 blank) |
| flash_en | input | 1 | Enables per-character flashing |
| blink_en | input | 1 | Blinks every character; overrides flashing |
| flash_attr | input | CHARS (8) | Flash attribute, one bit per character |
| row_idx | output | ROW_W (3) | Row currently being driven, 0 to ROWS-1 |
| row_strobe | output | 1 | One-cycle pulse at the start of each row slot |
| dot_en | output | 1 | Dot-drive gating enable for the current row |
| char_vis | output | CHARS (8) | Per-character visible mask |

## Verification
The assertions relate each registered output to the control inputs of the previous edge. They assume the inputs are synchronous to `clk` and hold one value across each edge. The bench changes inputs only 1.5 ns after a rising edge, well clear of both edges, so each value is sampled cleanly at exactly one edge. The blink and flash properties assume `blink_en` and `flash_en` are plain levels with no pulse shorter than a cycle, and the stimulus holds each setting for hundreds or thousands of clocks. The run sweeps all eight brightness codes, crosses two phase flips under different control modes and applies a reset in mid-run.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  localparam int BRIGHT_W = 3;
  localparam int SUBSLOTS = 15;

  // Lit sub-slots per row slot, out of SUBSLOTS, for each brightness code.
  function automatic logic [3:0] duty_slots(input logic [BRIGHT_W-1:0] code);
    logic [3:0] n;
    case (code)
      3'd0:    n = 4'd15;
      3'd1:    n = 4'd12;
      3'd2:    n = 4'd8;
      3'd3:    n = 4'd6;
      3'd4:    n = 4'd4;
      3'd5:    n = 4'd3;
      3'd6:    n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dmt_refresh_counter.sv
module dmt_refresh_counter #(
  parameter int SLOT_CLKS        = 32,
  parameter int ROWS             = 7,
  parameter int FRAMES_PER_PHASE = 128,
  localparam int SLOT_W  = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int FRAME_W = (FRAMES_PER_PHASE > 1) ? $clog2(FRAMES_PER_PHASE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic [ROW_W-1:0]  row_nxt,
  output logic              phase_nxt
);

  localparam logic [SLOT_W-1:0]  SLOT_LAST  = SLOT_W'(SLOT_CLKS - 1);
  localparam logic [ROW_W-1:0]   ROW_LAST   = ROW_W'(ROWS - 1);
  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAMES_PER_PHASE - 1);

  logic [SLOT_W-1:0]  slot_q;
  logic [ROW_W-1:0]   row_q;
  logic [FRAME_W-1:0] frame_q;
  logic               phase_q;
  logic [FRAME_W-1:0] frame_nxt;
  logic               slot_wrap, row_wrap, frame_wrap;

  // Cascaded counters: slot position, row, frame, then the phase bit.
  always_comb begin
    slot_wrap  = (slot_q == SLOT_LAST);
    row_wrap   = slot_wrap && (row_q == ROW_LAST);
    frame_wrap = row_wrap && (frame_q == FRAME_LAST);

    slot_nxt  = slot_wrap ? '0 : slot_q + 1'b1;
    row_nxt   = row_q;
    frame_nxt = frame_q;
    if (slot_wrap) row_nxt   = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    if (row_wrap)  frame_nxt = (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
    phase_nxt = phase_q ^ frame_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      row_q   <= '0;
      frame_q <= '0;
      phase_q <= 1'b0;
    end else begin
      slot_q  <= slot_nxt;
      row_q   <= row_nxt;
      frame_q <= frame_nxt;
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/dmt_duty_gate.sv
module dmt_duty_gate
  import dmt_pkg::*;
#(
  parameter int SLOT_W   = 5,
  parameter int SUB_CLKS = 2
) (
  input  logic [SLOT_W-1:0]   slot,
  input  logic [BRIGHT_W-1:0] code,
  output logic                en
);

  // Lit while the slot position is inside the first N sub-slots.
  always_comb begin
    en = (int'(slot) < SUB_CLKS * int'(duty_slots(code)));
  end

endmodule

// File: rtl/dmt_char_mask.sv
module dmt_char_mask #(
  parameter int CHARS = 8
) (
  input  logic             phase,
  input  logic             flash_en,
  input  logic             blink_en,
  input  logic [CHARS-1:0] attr,
  output logic [CHARS-1:0] vis
);

  // One selector per character: blink first, then the flash attribute.
  for (genvar i = 0; i < CHARS; i++) begin : g_char
    always_comb begin
      if (blink_en)
        vis[i] = ~phase;
      else if (flash_en && attr[i])
        vis[i] = ~phase;
      else
        vis[i] = 1'b1;
    end
  end

endmodule

// File: rtl/dot_matrix_timing.sv
module dot_matrix_timing
  import dmt_pkg::*;
#(
  parameter int CHARS            = 8,
  parameter int ROWS             = 7,
  parameter int SLOT_CLKS        = 32,
  parameter int SUB_CLKS         = 2,
  parameter int FRAMES_PER_PHASE = 128,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BRIGHT_W-1:0] bright_code,
  input  logic                flash_en,
  input  logic                blink_en,
  input  logic [CHARS-1:0]    flash_attr,
  output logic [ROW_W-1:0]    row_idx,
  output logic                row_strobe,
  output logic                dot_en,
  output logic [CHARS-1:0]    char_vis
);

  logic [SLOT_W-1:0] slot_nxt;
  logic [ROW_W-1:0]  row_nxt;
  logic              phase_nxt;
  logic              dot_nxt;
  logic [CHARS-1:0]  vis_nxt;

  dmt_refresh_counter #(
    .SLOT_CLKS        (SLOT_CLKS),
    .ROWS             (ROWS),
    .FRAMES_PER_PHASE (FRAMES_PER_PHASE)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .slot_nxt  (slot_nxt),
    .row_nxt   (row_nxt),
    .phase_nxt (phase_nxt)
  );

  dmt_duty_gate #(
    .SLOT_W   (SLOT_W),
    .SUB_CLKS (SUB_CLKS)
  ) u_gate (
    .slot (slot_nxt),
    .code (bright_code),
    .en   (dot_nxt)
  );

  dmt_char_mask #(
    .CHARS (CHARS)
  ) u_mask (
    .phase    (phase_nxt),
    .flash_en (flash_en),
    .blink_en (blink_en),
    .attr     (flash_attr),
    .vis      (vis_nxt)
  );

  // Outputs are registered from the counters' next state, so they line
  // up with the counter contents and need no extra delay stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx    <= '0;
      row_strobe <= 1'b0;
      dot_en     <= 1'b0;
      char_vis   <= '0;
    end else begin
      row_idx    <= row_nxt;
      row_strobe <= (slot_nxt == '0);
      dot_en     <= dot_nxt;
      char_vis   <= vis_nxt;
    end
  end

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int CHARS = 8,
  parameter int ROWS  = 7,
  parameter int ROW_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       bright_code,
  input logic             flash_en,
  input logic             blink_en,
  input logic [ROW_W-1:0] row_idx,
  input logic             row_strobe,
  input logic             dot_en,
  input logic [CHARS-1:0] char_vis
);

  p_strobe_advances_r1: assert property (@(posedge clk) disable iff (rst)
    row_strobe |-> (row_idx != $past(row_idx)));

  p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!row_strobe && !$past(rst)) |-> $stable(row_idx));

  p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(row_idx) < ROWS);

  p_slot_tail_dark_r3: assert property (@(posedge clk) disable iff (rst)
    row_strobe |-> !$past(dot_en));

  p_blank_code_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(bright_code) == 3'd7) |-> !dot_en);

  p_attr_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flash_en) && !$past(blink_en)) |-> (&char_vis));

  p_blink_uniform_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(blink_en)) |-> ((char_vis == '0) || (&char_vis)));

endmodule

bind dot_matrix_timing dmt_checker #(
  .CHARS (CHARS),
  .ROWS  (ROWS),
  .ROW_W (ROW_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bright_code (bright_code),
  .flash_en    (flash_en),
  .blink_en    (blink_en),
  .row_idx     (row_idx),
  .row_strobe  (row_strobe),
  .dot_en      (dot_en),
  .char_vis    (char_vis)
);

// File: tb/dot_matrix_timing_tb.sv
`timescale 1ns/100ps
module dot_matrix_timing_tb;

  localparam int CHARS = 8;

  typedef struct {
    logic [2:0]       row;
    logic             strobe;
    logic             dot;
    logic [CHARS-1:0] vis;
    bit               in_rst;
    int               mode;   // 0 none, 1 flash, 2 blink
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       bright_code = 3'd0;
  logic             flash_en = 1'b0;
  logic             blink_en = 1'b0;
  logic [CHARS-1:0] flash_attr = 8'hA5;
  logic [2:0]       row_idx;
  logic             row_strobe;
  logic             dot_en;
  logic [CHARS-1:0] char_vis;

  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  int   tcnt = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  dot_matrix_timing u_dut (
    .clk         (clk),
    .rst         (rst),
    .bright_code (bright_code),
    .flash_en    (flash_en),
    .blink_en    (blink_en),
    .flash_attr  (flash_attr),
    .row_idx     (row_idx),
    .row_strobe  (row_strobe),
    .dot_en      (dot_en),
    .char_vis    (char_vis)
  );

  // Lit sub-slot count per brightness code (R4).
  function automatic int lit_slots(input logic [2:0] c);
    int n;
    case (c)
      3'd0: n = 15;
      3'd1: n = 12;
      3'd2: n = 8;
      3'd3: n = 6;
      3'd4: n = 4;
      3'd5: n = 3;
      3'd6: n = 2;
      default: n = 0;
    endcase
    return n;
  endfunction

  // Driver: at each falling edge, predict what the next rising edge registers.
  always @(negedge clk) begin
    exp_t e;
    int   s;
    bit   ph;
    if (rst) begin
      tcnt = 0;
      e.row = '0; e.strobe = 1'b0; e.dot = 1'b0; e.vis = '0;
      e.in_rst = 1'b1; e.mode = 0;
    end else begin
      tcnt++;
      s  = tcnt % 32;
      ph = ((tcnt / 28672) % 2) == 1;
      e.in_rst = 1'b0;
      e.row    = 3'((tcnt / 32) % 7);
      e.strobe = (s == 0);
      e.dot    = (s < 2 * lit_slots(bright_code));
      e.mode   = blink_en ? 2 : (flash_en ? 1 : 0);
      for (int i = 0; i < CHARS; i++) begin
        if (blink_en || (flash_en && flash_attr[i])) e.vis[i] = ~ph;
        else e.vis[i] = 1'b1;
      end
    end
    sb.push_back(e);
  end

  // Monitor: 1 ns after each rising edge, compare against the oldest prediction.
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      if (e.in_rst) begin
        checks++;
        if ({row_idx, row_strobe, dot_en, char_vis} !== 13'd0) begin
          failures++;
          $display("FAIL R9 reset outputs actual=%h expected=0",
                   {row_idx, row_strobe, dot_en, char_vis});
        end
      end else begin
        checks++;
        if (row_strobe !== e.strobe) begin
          failures++;
          $display("FAIL R1 t=%0d strobe actual=%b expected=%b", tcnt, row_strobe, e.strobe);
        end
        checks++;
        if (row_idx !== e.row) begin
          failures++;
          $display("FAIL R2 t=%0d row actual=%0d expected=%0d", tcnt, row_idx, e.row);
        end
        checks++;
        if (dot_en !== e.dot) begin
          failures++;
          $display("FAIL R3 R4 R10 dot_en actual=%b expected=%b code=%0d",
                   dot_en, e.dot, bright_code);
        end
        checks++;
        if (char_vis !== e.vis) begin
          failures++;
          case (e.mode)
            0: $display("FAIL R5 R8 char_vis actual=%h expected=%h", char_vis, e.vis);
            1: $display("FAIL R6 R8 char_vis actual=%h expected=%h", char_vis, e.vis);
            default: $display("FAIL R7 R8 char_vis actual=%h expected=%h", char_vis, e.vis);
          endcase
        end
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1.5;
  endtask

  initial begin
    run(4);                       // R9 reset state
    rst = 1'b0;
    // R3 R4 R5: all brightness codes, attributes ignored with flash off
    for (int c = 0; c < 8; c++) begin
      bright_code = 3'(c);
      run(500);
    end
    // R6 R8: flash selected characters across the first phase flip
    flash_en = 1'b1; flash_attr = 8'h3C; bright_code = 3'd1;
    run(26000);
    // R7: blink overrides flash during the hidden phase
    blink_en = 1'b1;
    run(2000);
    // R7 R8: blink alone through the flip back to visible
    flash_en = 1'b0; bright_code = 3'd5;
    run(26500);
    blink_en = 1'b0; flash_en = 1'b1; flash_attr = 8'hFF; bright_code = 3'd2;
    run(500);
    // R9: mid-run reset realigns counters and phase
    rst = 1'b1;
    run(3);
    rst = 1'b0; blink_en = 1'b1;
    run(1000);
    run(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule